// File: doc/BRIEF.md
# Bidirectional Gate Scan Shift Driver

This block is the logic core of a display row-scan driver. One start pulse travels through a chain of `N_ROWS` stages, 256 by default, and moves one stage on each rising edge of the shift clock. A direction input sets the entry end and the exit end of the chain. The exit end passes the pulse to the next device in a cascade on a pin that is retimed to the falling clock edge.

Each stage drives one row output. Before a stage value reaches the row bus, two controls can change it, and both act without waiting for the clock. The rows are split into three interleaved groups by index modulo 3, and each group has a force-low control. A global active-low override drives every row high, and it wins over the group controls.

The two edge pins are bidirectional. Here each one is split into an input, an output value and an output drive-enable. The direction input picks which of the two pins drives.

Top module: `gsd_scan_driver`

## Requirements
- R1: While `rst_n` is low, every stage is cleared. With the overrides inactive (`all_on_n`=1, `grp_off`=0), every row reads 0 and both `left_out` and `right_out` read 0.
- R2: With `dir_up`=1, the rising edge that samples `left_in` high sets row 0. Each later rising edge moves the pulse one row toward row `N_ROWS`-1, so after rising edge k the pulse is on row k-1.
- R3: With `dir_up`=0, the rising edge that samples `right_in` high sets row `N_ROWS`-1. Each later rising edge moves the pulse one row toward row 0, so after rising edge k the pulse is on row `N_ROWS`-k.
- R4: With `dir_up`=1, `right_oe`=1 and `left_oe`=0. With `dir_up`=0, `left_oe`=1 and `right_oe`=0. The `_out` of the pin that is not driving reads 0.
- R5: Count the capture edge as rising edge 1. The cascade output (`right_out` when `dir_up`=1, `left_out` when `dir_up`=0) stays 0 before the falling edge that follows rising edge `N_ROWS`. It goes to 1 at that falling edge and returns to 0 at the falling edge that follows rising edge `N_ROWS`+1.
- R6: `grp_off[0]` forces low the rows whose 1-based number modulo 3 is 1. `grp_off[1]` does the same for remainder 2, and `grp_off[2]` for remainder 0. Row number = row index + 1. No other row is affected, and the effect is combinational.
- R7: While `all_on_n` is 0, every row reads 1, whatever `grp_off` and the stage contents are. The effect is combinational.
- R8: `grp_off` and `all_on_n` change only the row bus. The pulse keeps shifting underneath them, and once they are released the pulse shows on the row it would have reached without them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the chain moves on the rising edge, the cascade register loads on the falling edge |
| rst_n | input | 1 | Asynchronous active-low clear of the chain and the cascade register |
| dir_up | input | 1 | 1: scan from row 0 upward; 0: scan from row N_ROWS-1 downward |
| left_in | input | 1 | Left edge pin, input side (start pulse when dir_up=1) |
| left_out | output | 1 | Left edge pin, output value (cascade out when dir_up=0) |
| left_oe | output | 1 | Left edge pin drive-enable |
| right_in | input | 1 | Right edge pin, input side (start pulse when dir_up=0) |
| right_out | output | 1 | Right edge pin, output value (cascade out when dir_up=1) |
| right_oe | output | 1 | Right edge pin drive-enable |
| grp_off | input | N_GROUPS | Per-group force-low controls, active high |
| all_on_n | input | 1 | Global force-high override, active low |
| row_out | output | N_ROWS | Row drive bus, bit i is row number i+1 |

## Verification
The main overlap is a shift edge and an active override in the same cycle. The bench moves a pulse through the chain while `all_on_n` is held low and then while every group is forced off. In those cycles the row bus must show the override pattern alone. After release, the pulse must show exactly on the row that the count of rising edges predicts. A second overlap is the rising edge of a force-low group against the fully loaded chain, which is read as a vector compare against a mask built from the modulo-3 rule. The cascade pin is sampled both before and after the falling edge of clocks `N_ROWS` and `N_ROWS`+1, so a mistake of half a cycle is caught.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

   // Scan direction as seen on the dir_up pin.
   typedef enum logic {
      SCAN_DOWN = 1'b0,
      SCAN_UP   = 1'b1
   } scan_dir_e;

   // Enable group that owns a 0-based row index.
   function automatic int unsigned group_of(int unsigned row, int unsigned n_groups);
      return row % n_groups;
   endfunction

endpackage

// File: rtl/gsd_shift_chain.sv
module gsd_shift_chain #(
   parameter int unsigned N_ROWS = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_up,
   input  logic              left_in,
   input  logic              right_in,
   output logic [N_ROWS-1:0] stage_q
);
   import gsd_pkg::*;

   logic [N_ROWS-1:0] stage_d;

   always_comb begin
      if (scan_dir_e'(dir_up) == SCAN_UP)
         stage_d = {stage_q[N_ROWS-2:0], left_in};
      else
         stage_d = {right_in, stage_q[N_ROWS-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= stage_d;
   end

endmodule

// File: rtl/gsd_cascade_out.sv
module gsd_cascade_out #(
   parameter int unsigned N_ROWS = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_up,
   input  logic [N_ROWS-1:0] stage_q,
   output logic              left_out,
   output logic              left_oe,
   output logic              right_out,
   output logic              right_oe
);
   import gsd_pkg::*;

   localparam int unsigned LAST = N_ROWS - 1;

   logic exit_bit;
   logic casc_q;
   logic going_up;

   assign going_up = (scan_dir_e'(dir_up) == SCAN_UP);
   assign exit_bit = going_up ? stage_q[LAST] : stage_q[0];

   // Retimed to the falling edge so the next device sees half a cycle of setup.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) casc_q <= 1'b0;
      else        casc_q <= exit_bit;
   end

   assign right_oe  = going_up;
   assign left_oe   = !going_up;
   assign right_out = going_up  ? casc_q : 1'b0;
   assign left_out  = !going_up ? casc_q : 1'b0;

endmodule

// File: rtl/gsd_output_gate.sv
module gsd_output_gate #(
   parameter int unsigned N_ROWS   = 256,
   parameter int unsigned N_GROUPS = 3
) (
   input  logic [N_ROWS-1:0]   stage_q,
   input  logic [N_GROUPS-1:0] grp_off,
   input  logic                all_on_n,
   output logic [N_ROWS-1:0]   row_out
);
   import gsd_pkg::*;

   for (genvar i = 0; i < N_ROWS; i++) begin : g_row
      localparam int unsigned GRP = group_of(i, N_GROUPS);
      // Force-high wins over the group force-low.
      assign row_out[i] = !all_on_n | (stage_q[i] & !grp_off[GRP]);
   end

endmodule

// File: rtl/gsd_scan_driver.sv
module gsd_scan_driver #(
   parameter int unsigned N_ROWS   = 256,
   parameter int unsigned N_GROUPS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dir_up,
   input  logic                left_in,
   output logic                left_out,
   output logic                left_oe,
   input  logic                right_in,
   output logic                right_out,
   output logic                right_oe,
   input  logic [N_GROUPS-1:0] grp_off,
   input  logic                all_on_n,
   output logic [N_ROWS-1:0]   row_out
);

   if (N_ROWS < 2) begin : g_bad_rows
      $error("gsd_scan_driver: N_ROWS must be at least 2");
   end
   if (N_GROUPS < 1 || N_GROUPS > N_ROWS) begin : g_bad_groups
      $error("gsd_scan_driver: N_GROUPS must lie in 1..N_ROWS");
   end

   logic [N_ROWS-1:0] stage_q;

   gsd_shift_chain #(.N_ROWS(N_ROWS)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_up   (dir_up),
      .left_in  (left_in),
      .right_in (right_in),
      .stage_q  (stage_q)
   );

   gsd_cascade_out #(.N_ROWS(N_ROWS)) u_casc (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir_up    (dir_up),
      .stage_q   (stage_q),
      .left_out  (left_out),
      .left_oe   (left_oe),
      .right_out (right_out),
      .right_oe  (right_oe)
   );

   gsd_output_gate #(.N_ROWS(N_ROWS), .N_GROUPS(N_GROUPS)) u_gate (
      .stage_q  (stage_q),
      .grp_off  (grp_off),
      .all_on_n (all_on_n),
      .row_out  (row_out)
   );

endmodule

// File: rtl/gsd_scan_driver_chk.sv
module gsd_scan_driver_chk #(
   parameter int unsigned N_ROWS   = 256,
   parameter int unsigned N_GROUPS = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                dir_up,
   input logic                left_out,
   input logic                left_oe,
   input logic                right_out,
   input logic                right_oe,
   input logic [N_GROUPS-1:0] grp_off,
   input logic                all_on_n,
   input logic [N_ROWS-1:0]   row_out,
   input logic [N_ROWS-1:0]   stage_q
);

   logic [N_ROWS-1:0] off_mask;

   always_comb begin
      for (int i = 0; i < N_ROWS; i++) off_mask[i] = grp_off[i % N_GROUPS];
   end

   // R2: upward scan moves each stage one place toward the top.
   a_r2_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
      dir_up |=> stage_q[1] == $past(stage_q[0]));

   // R3: downward scan moves each stage one place toward row 0.
   a_r3_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_up |=> stage_q[N_ROWS-2] == $past(stage_q[N_ROWS-1]));

   // R4: exactly one edge pin drives at any time.
   a_r4_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({left_oe, right_oe}));

   // R5: cascade pin follows the exit stage one falling edge later.
   a_r5_casc_up: assert property (@(negedge clk) disable iff (!rst_n)
      dir_up |=> (!dir_up || right_out == $past(stage_q[N_ROWS-1])));

   a_r5_casc_down: assert property (@(negedge clk) disable iff (!rst_n)
      !dir_up |=> (dir_up || left_out == $past(stage_q[0])));

   // R6: a forced-off group shows no high row unless the global override is on.
   a_r6_group_low: assert property (@(posedge clk) disable iff (!rst_n)
      all_on_n |-> (row_out & off_mask) == '0);

   // R7: global override drives every row high.
   a_r7_all_high: assert property (@(posedge clk) disable iff (!rst_n)
      !all_on_n |-> &row_out);

endmodule

bind gsd_scan_driver gsd_scan_driver_chk #(.N_ROWS(N_ROWS), .N_GROUPS(N_GROUPS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dir_up    (dir_up),
   .left_out  (left_out),
   .left_oe   (left_oe),
   .right_out (right_out),
   .right_oe  (right_oe),
   .grp_off   (grp_off),
   .all_on_n  (all_on_n),
   .row_out   (row_out),
   .stage_q   (stage_q)
);

// File: tb/gsd_scan_driver_test.sv
module gsd_scan_driver_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int N = 256;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         dir_up;
   logic         left_in, right_in;
   logic         left_out, left_oe, right_out, right_oe;
   logic [2:0]   grp_off;
   logic         all_on_n;
   logic [N-1:0] row_out;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   gsd_scan_driver #(.N_ROWS(N), .N_GROUPS(3)) uut (
      .clk(clk), .rst_n(rst_n), .dir_up(dir_up),
      .left_in(left_in), .left_out(left_out), .left_oe(left_oe),
      .right_in(right_in), .right_out(right_out), .right_oe(right_oe),
      .grp_off(grp_off), .all_on_n(all_on_n), .row_out(row_out)
   );

   task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] one_at(int idx);
      logic [N-1:0] v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction

   // Row bus expected from stage contents and the gating rules.
   function automatic logic [N-1:0] gate_exp(logic [N-1:0] s, logic [2:0] g, logic on_n);
      logic [N-1:0] v;
      for (int i = 0; i < N; i++)
         v[i] = !on_n ? 1'b1 : (g[(i + 1) % 3 == 1 ? 0 : ((i + 1) % 3 == 2 ? 1 : 2)] ? 1'b0 : s[i]);
      return v;
   endfunction

   // Returns 6 ns after a rising edge, i.e. after the following falling edge.
   task automatic tick();
      @(posedge clk);
      #6;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; dir_up = 1'b1; left_in = 1'b0; right_in = 1'b0;
      grp_off = 3'b000; all_on_n = 1'b1;
      repeat (2) @(posedge clk);
      #6;
      chk("R1 rows cleared", row_out, '0);
      chk("R1 right_out low", {{(N-1){1'b0}}, right_out}, '0);
      chk("R1 left_out low", {{(N-1){1'b0}}, left_out}, '0);
      rst_n = 1'b1;
   endtask

   task automatic t_scan(bit up);
      string rq = up ? "R2" : "R3";
      dir_up = up;
      #1;
      chk("R4 right_oe", {{(N-1){1'b0}}, right_oe}, {{(N-1){1'b0}}, up});
      chk("R4 left_oe", {{(N-1){1'b0}}, left_oe}, {{(N-1){1'b0}}, !up});
      if (up) left_in = 1'b1; else right_in = 1'b1;
      tick();
      chk({rq, " capture"}, row_out, one_at(up ? 0 : N - 1));
      left_in = 1'b0; right_in = 1'b0;
      for (int k = 2; k <= N; k++) begin
         if (k == N) begin
            @(posedge clk);
            #2;
            chk("R5 casc low before fall N", {{(N-1){1'b0}}, up ? right_out : left_out}, '0);
            #4;
            chk("R5 casc high after fall N", {{(N-1){1'b0}}, up ? right_out : left_out}, 1);
            chk("R4 idle pin low", {{(N-1){1'b0}}, up ? left_out : right_out}, '0);
         end else begin
            tick();
            if (k == N - 1)
               chk("R5 casc low at N-1", {{(N-1){1'b0}}, up ? right_out : left_out}, '0);
         end
         if (k == 2 || k == 3 || k == N / 2 || k == N)
            chk({rq, " walk"}, row_out, one_at(up ? k - 1 : N - k));
      end
      @(posedge clk);
      #2;
      chk("R5 casc still high before fall N+1", {{(N-1){1'b0}}, up ? right_out : left_out}, 1);
      #4;
      chk("R5 casc low after fall N+1", {{(N-1){1'b0}}, up ? right_out : left_out}, '0);
      chk({rq, " chain empty"}, row_out, '0);
   endtask

   task automatic t_groups();
      logic [N-1:0] ones = '1;
      dir_up = 1'b1; left_in = 1'b1;
      repeat (N) tick();
      chk("R2 chain full", row_out, ones);
      for (int g = 0; g < 8; g++) begin
         grp_off = 3'(g);
         #1;
         chk("R6 group mask", row_out, gate_exp(ones, grp_off, 1'b1));
      end
      grp_off = 3'b001; #1;
      chk("R6 row1 low", {{(N-1){1'b0}}, row_out[0]}, '0);
      chk("R6 row2 high", {{(N-1){1'b0}}, row_out[1]}, 1);
      grp_off = 3'b100; #1;
      chk("R6 row3 low", {{(N-1){1'b0}}, row_out[2]}, '0);
      chk("R6 row256 high", {{(N-1){1'b0}}, row_out[N-1]}, 1);
      grp_off = 3'b111; all_on_n = 1'b0; #1;
      chk("R7 override beats groups", row_out, ones);
      all_on_n = 1'b1; grp_off = 3'b000; left_in = 1'b0;
   endtask

   task automatic t_override_mid_scan();
      t_reset();
      dir_up = 1'b1;
      all_on_n = 1'b0; #1;
      chk("R7 override on empty chain", row_out, '1);
      all_on_n = 1'b1;
      left_in = 1'b1;
      tick();
      left_in = 1'b0;
      all_on_n = 1'b0;
      repeat (4) begin
         tick();
         chk("R7 override during scan", row_out, '1);
      end
      all_on_n = 1'b1; grp_off = 3'b111;
      repeat (3) begin
         tick();
         chk("R8 groups hide pulse", row_out, '0);
      end
      grp_off = 3'b000; #1;
      chk("R8 pulse position kept", row_out, one_at(7));
      tick();
      chk("R8 pulse keeps moving", row_out, one_at(8));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_scan(1'b1);
      t_reset();
      t_scan(1'b0);
      t_reset();
      t_groups();
      t_override_mid_scan();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

endmodule